// File: doc/BRIEF.md
# Machine-Check and Interrupt Exception Controller

This block sits next to a small processor core and decides what happens when a machine-check condition or an external interrupt request arrives. It holds the two enable bits of the machine status register: the machine-check enable and the external-interrupt enable. Software loads both bits through a write strobe. When a request is serviced, the block emits a one-cycle exception strobe together with the target vector address.

When a machine check arrives while machine checks are disabled, the block does not vector. It latches a checkstop state instead and raises a freeze output that halts the core's state latches. The freeze path is a short register chain. It keeps the freeze timing inside a two-cycle budget and still gives the wire a full cycle to cross the chip. Only the asynchronous reset leaves checkstop.

External interrupts are level requests. They are masked by their enable bit, and they are held off while the core reports a higher-priority exception pending. Taking an interrupt does not acknowledge the source. The block clears the external-interrupt enable instead, and the handler sets it again when it is ready.

Top module: `mcx_ctrl`

## Requirements
- R1: After reset, `chkstop_o`, `freeze_o`, `exc_take_o`, `msr_me_o` and `msr_ee_o` are all 0, and `exc_vec_o` is 0.
- R2: A machine check sampled while `msr_me_o`=1 gives `exc_take_o`=1 with `exc_vec_o`=0x200 in the next cycle. In that cycle `msr_me_o` stays 1 and `msr_ee_o` reads 0.
- R3: A machine check sampled while `msr_me_o`=0 sets `chkstop_o` in the next cycle, and no exception strobe is produced.
- R4: `freeze_o` is asserted no later than two cycles after `chkstop_o` rises. With the default single freeze stage, it rises exactly one cycle after `chkstop_o`.
- R5: Once set, `chkstop_o` and `freeze_o` stay set until reset. While they are set, `mchk_i`, `ext_irq_i` and register writes have no effect: there is no strobe and both enable bits hold their values. Reset clears checkstop.
- R6: `ext_irq_i`=1 sampled with `msr_ee_o`=1, `hp_pend_i`=0 and no machine check gives `exc_take_o`=1 with `exc_vec_o`=0x500 in the next cycle, and `msr_ee_o` is 0 in that cycle.
- R7: While `msr_ee_o`=0, `ext_irq_i` produces no strobe.
- R8: While `hp_pend_i`=1, the external interrupt is deferred. It is taken in the cycle after `hp_pend_i` falls, provided the line is still high and enabled.
- R9: When a machine check and an external interrupt are sampled in the same cycle, only the machine check is taken (vector 0x200). Because the enable bit is then cleared, the interrupt is not taken afterwards.
- R10: `exc_take_o` lasts one cycle per serviced event, and `exc_vec_o` is 0 whenever `exc_take_o` is 0.
- R11: Taking the interrupt does not consume the request. If the line is still high when `msr_ee_o` is written back to 1, the interrupt is taken again.
- R12: `msr_we_i`=1 loads `msr_me_d_i` and `msr_ee_d_i` into the enable bits on the next edge. If an exception is taken on the same edge, the cleared external enable wins over the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mchk_i | input | 1 | Machine-check condition pulse |
| ext_irq_i | input | 1 | Level-sensitive external interrupt request |
| hp_pend_i | input | 1 | Higher-priority exception pending in the core |
| msr_we_i | input | 1 | Write strobe for the enable bits |
| msr_me_d_i | input | 1 | Machine-check enable write value |
| msr_ee_d_i | input | 1 | External-interrupt enable write value |
| msr_me_o | output | 1 | Current machine-check enable |
| msr_ee_o | output | 1 | Current external-interrupt enable |
| exc_take_o | output | 1 | One-cycle exception-taken strobe |
| exc_vec_o | output | VEC_W | Vector address, valid with the strobe |
| chkstop_o | output | 1 | Checkstop state |
| freeze_o | output | 1 | Halts the core's state latches |

## Verification
A checkstop flag that was lost or set spuriously shows up at `chkstop_o` on the edge after the machine check. Within one more edge it also shows up at `freeze_o`, or as a strobe that should not have appeared. A wrong enable bit appears directly on `msr_me_o` or `msr_ee_o`. From one cycle later it also appears as a missing, extra or repeated strobe while the interrupt line is held high. Priority or vector mix-ups are visible on `exc_vec_o` in the single strobe cycle, so the bench samples the vector exactly there and checks that it is zero in the cycles around it.

// File: rtl/mcx_pkg.sv
package mcx_pkg;
  localparam logic [31:0] MC_VEC  = 32'h0000_0200;
  localparam logic [31:0] EXT_VEC = 32'h0000_0500;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_MC   = 2'd1,
    CAUSE_EXT  = 2'd2
  } cause_e;
endpackage

// File: rtl/mcx_prio.sv
module mcx_prio
  import mcx_pkg::*;
(
  input  logic   mchk_i,
  input  logic   ext_irq_i,
  input  logic   hp_pend_i,
  input  logic   me_i,
  input  logic   ee_i,
  input  logic   cs_i,
  output cause_e cause_o,
  output logic   enter_cs_o
);
  always_comb begin
    cause_o    = CAUSE_NONE;
    enter_cs_o = 1'b0;
    if (!cs_i) begin
      if (mchk_i) begin
        if (me_i) cause_o = CAUSE_MC;
        else      enter_cs_o = 1'b1;
      end else if (ext_irq_i && ee_i && !hp_pend_i) begin
        cause_o = CAUSE_EXT;
      end
    end
  end
endmodule

// File: rtl/mcx_msr.sv
module mcx_msr
  import mcx_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   hold_i,
  input  cause_e cause_i,
  input  logic   we_i,
  input  logic   me_d_i,
  input  logic   ee_d_i,
  output logic   me_o,
  output logic   ee_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      me_o <= 1'b0;
      ee_o <= 1'b0;
    end else if (!hold_i) begin
      if (we_i) me_o <= me_d_i;
      if (cause_i != CAUSE_NONE) begin
        ee_o <= 1'b0;
        if (cause_i == CAUSE_MC) me_o <= 1'b1;  // stays enabled to run the handler
      end else if (we_i) begin
        ee_o <= ee_d_i;
      end
    end
  end
endmodule

// File: rtl/mcx_cstop.sv
module mcx_cstop #(
  parameter int unsigned FRZ_STAGES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enter_i,
  output logic cs_o,
  output logic frz_o
);
  logic [FRZ_STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cs_o <= 1'b0;
    else if (enter_i) cs_o <= 1'b1;
  end

  assign chain_q[0] = cs_o;

  for (genvar i = 0; i < FRZ_STAGES; i++) begin : g_frz
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[i+1] <= 1'b0;
      else         chain_q[i+1] <= chain_q[i];
    end
  end

  assign frz_o = chain_q[FRZ_STAGES];
endmodule

// File: rtl/mcx_ctrl.sv
module mcx_ctrl
  import mcx_pkg::*;
#(
  parameter int unsigned VEC_W      = 32,
  parameter int unsigned FRZ_STAGES = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mchk_i,
  input  logic             ext_irq_i,
  input  logic             hp_pend_i,
  input  logic             msr_we_i,
  input  logic             msr_me_d_i,
  input  logic             msr_ee_d_i,
  output logic             msr_me_o,
  output logic             msr_ee_o,
  output logic             exc_take_o,
  output logic [VEC_W-1:0] exc_vec_o,
  output logic             chkstop_o,
  output logic             freeze_o
);
  localparam logic [VEC_W-1:0] MC_V  = VEC_W'(MC_VEC);
  localparam logic [VEC_W-1:0] EXT_V = VEC_W'(EXT_VEC);

  cause_e cause;
  logic   enter_cs;

  mcx_prio u_prio (
    .mchk_i     (mchk_i),
    .ext_irq_i  (ext_irq_i),
    .hp_pend_i  (hp_pend_i),
    .me_i       (msr_me_o),
    .ee_i       (msr_ee_o),
    .cs_i       (chkstop_o),
    .cause_o    (cause),
    .enter_cs_o (enter_cs)
  );

  mcx_msr u_msr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hold_i  (chkstop_o),
    .cause_i (cause),
    .we_i    (msr_we_i),
    .me_d_i  (msr_me_d_i),
    .ee_d_i  (msr_ee_d_i),
    .me_o    (msr_me_o),
    .ee_o    (msr_ee_o)
  );

  mcx_cstop #(.FRZ_STAGES(FRZ_STAGES)) u_cstop (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enter_i (enter_cs),
    .cs_o    (chkstop_o),
    .frz_o   (freeze_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_take_o <= 1'b0;
      exc_vec_o  <= '0;
    end else begin
      exc_take_o <= (cause != CAUSE_NONE);
      unique case (cause)
        CAUSE_MC:  exc_vec_o <= MC_V;
        CAUSE_EXT: exc_vec_o <= EXT_V;
        default:   exc_vec_o <= '0;
      endcase
    end
  end
endmodule

// File: rtl/mcx_ctrl_chk.sv
module mcx_ctrl_chk #(
  parameter int unsigned VEC_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mchk_i,
  input logic             ext_irq_i,
  input logic             hp_pend_i,
  input logic             msr_we_i,
  input logic             msr_me_o,
  input logic             msr_ee_o,
  input logic             exc_take_o,
  input logic [VEC_W-1:0] exc_vec_o,
  input logic             chkstop_o,
  input logic             freeze_o
);
  localparam logic [VEC_W-1:0] MC_V  = VEC_W'(32'h200);
  localparam logic [VEC_W-1:0] EXT_V = VEC_W'(32'h500);

  AST_MC_VECTORS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mchk_i && msr_me_o && !chkstop_o |=> exc_take_o && exc_vec_o == MC_V && msr_me_o); // R2
  AST_CS_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mchk_i && !msr_me_o && !chkstop_o |=> chkstop_o && !exc_take_o); // R3
  AST_FRZ_BUDGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chkstop_o && $past(chkstop_o) |-> freeze_o); // R4
  AST_CS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chkstop_o |=> chkstop_o && $stable(msr_me_o) && $stable(msr_ee_o)); // R5
  AST_CS_NO_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chkstop_o |-> !exc_take_o); // R5
  AST_EE_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_take_o |-> !msr_ee_o); // R6
  AST_EXT_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msr_ee_o && !mchk_i |=> !exc_take_o); // R7
  AST_EXT_DEFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hp_pend_i && !mchk_i |=> !exc_take_o); // R8
  AST_VEC_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_take_o |-> exc_vec_o == '0); // R10
  AST_VEC_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_take_o |-> exc_vec_o == MC_V || exc_vec_o == EXT_V); // R10

  logic unused_ok;
  assign unused_ok = ext_irq_i ^ msr_we_i;
endmodule

bind mcx_ctrl mcx_ctrl_chk #(.VEC_W(VEC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mchk_i     (mchk_i),
  .ext_irq_i  (ext_irq_i),
  .hp_pend_i  (hp_pend_i),
  .msr_we_i   (msr_we_i),
  .msr_me_o   (msr_me_o),
  .msr_ee_o   (msr_ee_o),
  .exc_take_o (exc_take_o),
  .exc_vec_o  (exc_vec_o),
  .chkstop_o  (chkstop_o),
  .freeze_o   (freeze_o)
);

// File: tb/mcx_ctrl_tb_top.sv
module mcx_ctrl_tb_top;
  localparam int VEC_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mchk = 1'b0, irq = 1'b0, hp = 1'b0;
  logic we = 1'b0, me_d = 1'b0, ee_d = 1'b0;
  logic me, ee, take, cs, frz;
  logic [VEC_W-1:0] vec;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mcx_ctrl #(.VEC_W(VEC_W)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .mchk_i     (mchk),
    .ext_irq_i  (irq),
    .hp_pend_i  (hp),
    .msr_we_i   (we),
    .msr_me_d_i (me_d),
    .msr_ee_d_i (ee_d),
    .msr_me_o   (me),
    .msr_ee_o   (ee),
    .exc_take_o (take),
    .exc_vec_o  (vec),
    .chkstop_o  (cs),
    .freeze_o   (frz)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    {mchk, irq, hp, we, me_d, ee_d} = '0;
    rst_n = 1'b0;
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
  endtask

  task automatic wr(input logic m, input logic e);
    we = 1'b1; me_d = m; ee_d = e;
    cyc();
    we = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 chkstop", 32'(cs), 0);
    chk("R1 freeze", 32'(frz), 0);
    chk("R1 take", 32'(take), 0);
    chk("R1 vec", vec, 0);
    chk("R1 me", 32'(me), 0);
    chk("R1 ee", 32'(ee), 0);
  endtask

  task automatic t_write();
    do_reset();
    wr(1, 1);
    chk("R12 me loaded", 32'(me), 1);
    chk("R12 ee loaded", 32'(ee), 1);
    wr(0, 1);
    chk("R12 me reloaded", 32'(me), 0);
  endtask

  task automatic t_ext_and_retrigger();
    do_reset();
    wr(0, 1);
    irq = 1'b1;
    cyc();
    chk("R6 take", 32'(take), 1);
    chk("R6 vec", vec, 32'h500);
    chk("R6 ee cleared", 32'(ee), 0);
    cyc();
    chk("R10 single pulse", 32'(take), 0);
    chk("R10 vec zero", vec, 0);
    cyc();
    chk("R7 held line masked", 32'(take), 0);
    wr(0, 1);
    chk("R11 ee rewritten", 32'(ee), 1);
    cyc();
    chk("R11 retaken", 32'(take), 1);
    chk("R11 vec", vec, 32'h500);
    irq = 1'b0;
    cyc();
  endtask

  task automatic t_masked();
    do_reset();
    irq = 1'b1;
    for (int i = 0; i < 3; i++) begin
      cyc();
      chk("R7 masked", 32'(take), 0);
    end
    irq = 1'b0;
  endtask

  task automatic t_defer();
    do_reset();
    wr(0, 1);
    irq = 1'b1; hp = 1'b1;
    cyc();
    chk("R8 deferred", 32'(take), 0);
    cyc();
    chk("R8 still deferred", 32'(take), 0);
    chk("R8 ee kept", 32'(ee), 1);
    hp = 1'b0;
    cyc();
    chk("R8 taken after", 32'(take), 1);
    chk("R8 vec", vec, 32'h500);
    irq = 1'b0;
  endtask

  task automatic t_both();
    do_reset();
    wr(1, 1);
    mchk = 1'b1; irq = 1'b1;
    cyc();
    mchk = 1'b0;
    chk("R9 mc wins take", 32'(take), 1);
    chk("R9 mc vec", vec, 32'h200);
    chk("R2 me kept", 32'(me), 1);
    chk("R2 ee cleared", 32'(ee), 0);
    cyc();
    chk("R9 no ext follow", 32'(take), 0);
    chk("R9 no chkstop", 32'(cs), 0);
    irq = 1'b0;
  endtask

  task automatic t_write_collide();
    do_reset();
    wr(0, 1);
    irq = 1'b1; we = 1'b1; me_d = 1'b1; ee_d = 1'b1;
    cyc();
    we = 1'b0; irq = 1'b0;
    chk("R12 take wins", 32'(take), 1);
    chk("R12 ee cleared over write", 32'(ee), 0);
    chk("R12 me written", 32'(me), 1);
  endtask

  task automatic t_chkstop();
    do_reset();
    mchk = 1'b1;
    cyc();
    mchk = 1'b0;
    chk("R3 chkstop set", 32'(cs), 1);
    chk("R3 no take", 32'(take), 0);
    cyc();
    chk("R4 freeze", 32'(frz), 1);
    irq = 1'b1; mchk = 1'b1; we = 1'b1; me_d = 1'b1; ee_d = 1'b1;
    for (int i = 0; i < 3; i++) begin
      cyc();
      chk("R5 no take", 32'(take), 0);
      chk("R5 held", 32'(cs & frz), 1);
      chk("R5 me frozen", 32'(me), 0);
      chk("R5 ee frozen", 32'(ee), 0);
    end
    {irq, mchk, we} = '0;
    do_reset();
    chk("R5 reset releases", 32'(cs), 0);
    chk("R5 freeze released", 32'(frz), 0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_write();
    t_ext_and_retrigger();
    t_masked();
    t_defer();
    t_both();
    t_write_collide();
    t_chkstop();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule